// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. After power-on it takes the memory to a usable state. While reset is held it keeps clock enable high, keeps every data mask bit high, and places a no-operation command on the command pins. Once reset is released it waits through a stabilization window, then closes every bank. It follows with a set of auto refreshes, loads the mode register, and loads the extended mode register. It then raises a completion flag, and normal traffic can start from that point.

All timing is given in nanoseconds together with the clock period. The block turns each value into a whole number of clocks, always rounding up. The number of refreshes and the two register operation codes are parameters. The gap after each register load is never allowed below two clocks. Every output is registered. A cycle that issues no command drives a no-operation: chip select low, and the row strobe, column strobe and write enable all high.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and on the first cycle after reset is released, the outputs are a no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), CKE high, every DQM bit high, address 0, bank 0, and init_done low.
- R2: After the edge that releases reset, exactly ceil(T_STABLE_NS/CLK_PERIOD_NS) no-operation cycles appear. The next command is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 high, every other address bit 0, bank 0.
- R3: The first auto refresh comes exactly ceil(T_RP_NS/CLK_PERIOD_NS) clocks after the precharge-all.
- R4: Exactly REF_COUNT auto refreshes are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1, address 0). Each one is followed by ceil(T_RC_NS/CLK_PERIOD_NS) clocks before the next command.
- R5: The mode register load (all four command pins low) carries bank 0 and MODE_OP on the address. It comes right after the refresh gap of the last refresh.
- R6: The extended mode register load (all four command pins low) carries bank 1 and EXT_OP on the address. It follows the mode register load after max(MRD_CYCLES,2) clocks.
- R7: init_done rises max(MRD_CYCLES,2) clocks after the extended register load and then stays high. DQM goes low on the same edge that init_done rises.
- R8: Every cycle that carries none of the commands above drives a no-operation. After init_done only no-operations appear. CKE is high throughout.
- R9: If reset is applied partway through the sequence, the outputs return to the R1 state, and the whole sequence restarts with the same timing once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed address / operation code |
| sd_dqm | output | DQM_W | Data mask bits |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds the block with a 15 ns clock, a 300 ns stabilization window, a 30 ns precharge time, a 70 ns row cycle, three refreshes, and MRD_CYCLES set to 1. With these values the stabilization wait is short enough to sweep cycle by cycle. The row cycle time is not a whole multiple of the period, so the round-up is exercised. Three refreshes show that the count is honoured beyond the minimum of two. The requested register gap of one clock has to be lifted to the two-clock floor. Distinct non-zero operation codes make it visible if the two register loads are swapped.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_REF, ST_MRS, ST_EMRS, ST_TAIL, ST_DONE
  } init_state_t;

  typedef enum logic [2:0] {
    OP_NOP, OP_PRE, OP_REF, OP_MRS, OP_EMRS
  } init_op_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                 count_q <= TW'(RST_VAL);
    else if (load)           count_q <= load_val;
    else if (count_q != '0)  count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int TW        = 8,
  parameter int TRP_C     = 2,
  parameter int TRC_C     = 7,
  parameter int MRD_C     = 2,
  parameter int REF_COUNT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expired,
  output logic          load,
  output logic [TW-1:0] load_val,
  output init_op_t      op,
  output logic          done_set
);
  localparam int RW = $clog2(REF_COUNT + 1);

  init_state_t   state_q, state_d;
  logic [RW-1:0] ref_left_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    op       = OP_NOP;
    done_set = 1'b0;
    if (expired) begin
      case (state_q)
        ST_WAIT: state_d = ST_PRE;
        ST_PRE: begin
          op = OP_PRE; load = 1'b1; load_val = TW'(TRP_C - 1); state_d = ST_REF;
        end
        ST_REF: begin
          op = OP_REF; load = 1'b1; load_val = TW'(TRC_C - 1);
          if (ref_left_q == RW'(1)) state_d = ST_MRS;
        end
        ST_MRS: begin
          op = OP_MRS; load = 1'b1; load_val = TW'(MRD_C - 1); state_d = ST_EMRS;
        end
        ST_EMRS: begin
          op = OP_EMRS; load = 1'b1; load_val = TW'(MRD_C - 1); state_d = ST_TAIL;
        end
        ST_TAIL: begin
          done_set = 1'b1; state_d = ST_DONE;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT;
      ref_left_q <= RW'(REF_COUNT);
    end else begin
      state_q <= state_d;
      if (op == OP_REF) ref_left_q <= ref_left_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int               CLK_PERIOD_NS = 10,
  parameter int               T_STABLE_NS   = 200000,
  parameter int               T_RP_NS       = 20,
  parameter int               T_RC_NS       = 70,
  parameter int               MRD_CYCLES    = 2,
  parameter int               REF_COUNT     = 2,
  parameter int               ADDR_W        = 11,
  parameter int               BA_W          = 1,
  parameter int               DQM_W         = 2,
  parameter int               AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_OP      = 11'h022,
  parameter logic [ADDR_W-1:0] EXT_OP       = 11'h000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  localparam int STABLE_C = max_int(ceil_div(T_STABLE_NS, CLK_PERIOD_NS), 1);
  localparam int TRP_C    = max_int(ceil_div(T_RP_NS, CLK_PERIOD_NS), 1);
  localparam int TRC_C    = max_int(ceil_div(T_RC_NS, CLK_PERIOD_NS), 1);
  localparam int MRD_C    = max_int(MRD_CYCLES, 2);
  localparam int MAX_C    = max_int(max_int(STABLE_C, TRP_C), max_int(TRC_C, MRD_C));
  localparam int TW       = $clog2(MAX_C + 1);

  logic          expired, load, done_set;
  logic [TW-1:0] load_val;
  init_op_t      op;

  sdram_init_timer #(.TW(TW), .RST_VAL(STABLE_C - 1)) timer_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  sdram_init_fsm #(
    .TW(TW), .TRP_C(TRP_C), .TRC_C(TRC_C), .MRD_C(MRD_C), .REF_COUNT(REF_COUNT)
  ) fsm_i (
    .clk(clk), .rst(rst), .expired(expired), .load(load),
    .load_val(load_val), .op(op), .done_set(done_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cke    <= 1'b1;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= '1;
      init_done <= 1'b0;
    end else begin
      sd_cke  <= 1'b1;
      sd_ba   <= '0;
      sd_addr <= '0;
      case (op)
        OP_PRE: begin
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0010;
          sd_addr[AP_BIT] <= 1'b1;
        end
        OP_REF:  {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0001;
        OP_MRS: begin
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0000;
          sd_addr <= MODE_OP;
        end
        OP_EMRS: begin
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0000;
          sd_addr <= EXT_OP;
          sd_ba   <= BA_W'(1);
        end
        default: {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      endcase
      init_done <= init_done | done_set;
      sd_dqm    <= (init_done | done_set) ? '0 : '1;
    end
  end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int               ADDR_W  = 11,
  parameter int               BA_W    = 1,
  parameter int               DQM_W   = 2,
  parameter int               AP_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_OP = '0,
  parameter logic [ADDR_W-1:0] EXT_OP  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done
);
  logic [3:0] cmd;
  logic is_nop, is_pre, is_mrs;
  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop = (cmd == 4'b0111);
  assign is_pre = (cmd == 4'b0010);
  assign is_mrs = (cmd == 4'b0000);

  assert_cke_high_R8: assert property (@(posedge clk) disable iff (rst) sd_cke);
  assert_nop_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  assert_dqm_masked_R1: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (&sd_dqm));
  assert_reg_gap_R6: assert property (@(posedge clk) disable iff (rst)
    is_mrs |=> is_nop);
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> sd_addr[AP_BIT]);
  assert_mode_op_R5: assert property (@(posedge clk) disable iff (rst)
    (is_mrs && sd_ba == '0) |-> (sd_addr == MODE_OP));
  assert_ext_op_R6: assert property (@(posedge clk) disable iff (rst)
    (is_mrs && sd_ba == BA_W'(1)) |-> (sd_addr == EXT_OP));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT),
  .MODE_OP(MODE_OP), .EXT_OP(EXT_OP)
) chk_i (
  .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
  .sd_dqm(sd_dqm), .init_done(init_done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
  localparam int CLK_NS  = 15;
  localparam int STAB_NS = 300;
  localparam int TRP_NS  = 30;
  localparam int TRC_NS  = 70;
  localparam int REFN    = 3;
  localparam logic [10:0] MODE_V = 11'h032;
  localparam logic [10:0] EXT_V  = 11'h040;
  // expected clock counts: 20 stable, 2 precharge, 5 row cycle, 2 register gap
  localparam int E_PRE  = 21;
  localparam int E_REF0 = E_PRE + 2;
  localparam int E_MRS  = E_REF0 + REFN * 5;
  localparam int E_EMRS = E_MRS + 2;
  localparam int E_DONE = E_EMRS + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [0:0]  sd_ba;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;
  int checks = 0;
  int fails  = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  sdram_init_seq #(
    .CLK_PERIOD_NS(CLK_NS), .T_STABLE_NS(STAB_NS), .T_RP_NS(TRP_NS),
    .T_RC_NS(TRC_NS), .MRD_CYCLES(1), .REF_COUNT(REFN),
    .MODE_OP(MODE_V), .EXT_OP(EXT_V)
  ) dut_i (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 NOP, 1 PRE, 2 REF, 3 MRS, 4 EMRS, 7 illegal
  function automatic int act_op();
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return (sd_ba == 1'b1) ? 4 : 3;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_op(input int n);
    if (n == E_PRE) return 1;
    for (int i = 0; i < REFN; i++) if (n == E_REF0 + i * 5) return 2;
    if (n == E_MRS)  return 3;
    if (n == E_EMRS) return 4;
    return 0;
  endfunction

  task automatic check_idle(input string req);
    check(act_op() == 0, req, "idle command", act_op(), 0);
    check(sd_cke === 1'b1, req, "cke", sd_cke, 1);
    check(sd_dqm === 2'b11, req, "dqm", sd_dqm, 3);
    check(init_done === 1'b0, req, "done", init_done, 0);
    check(sd_addr === '0 && sd_ba === '0, req, "addr/ba", sd_addr, 0);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
  endtask

  // releases reset and follows the whole sequence cycle by cycle
  task automatic t_sequence(input string tag);
    rst = 1'b0;
    for (int n = 1; n <= E_DONE + 6; n++) begin
      int e;
      string req;
      @(negedge clk);
      e = exp_op(n);
      case (e)
        1: req = "R2";
        2: req = (n == E_REF0) ? "R3" : "R4";
        3: req = "R5";
        4: req = "R6";
        default: req = "R8";
      endcase
      if (n == 1) check_idle("R1");
      check(act_op() == e, {tag, " ", req}, $sformatf("command at cycle %0d", n), act_op(), e);
      check(sd_cke === 1'b1, {tag, " R8"}, "cke", sd_cke, 1);
      if (e == 1) check(sd_addr == 11'h400 && sd_ba == 1'b0, {tag, " R2"}, "precharge-all addr", sd_addr, 11'h400);
      if (e == 2) check(sd_addr == '0, {tag, " R4"}, "refresh addr", sd_addr, 0);
      if (e == 3) check(sd_addr == MODE_V, {tag, " R5"}, "mode op", sd_addr, MODE_V);
      if (e == 4) check(sd_addr == EXT_V, {tag, " R6"}, "ext op", sd_addr, EXT_V);
      check(init_done === (n >= E_DONE), {tag, " R7"}, $sformatf("done at cycle %0d", n), init_done, n >= E_DONE);
      check(sd_dqm === ((n >= E_DONE) ? 2'b00 : 2'b11), {tag, " R7"}, $sformatf("dqm at cycle %0d", n),
            sd_dqm, (n >= E_DONE) ? 0 : 3);
    end
  endtask

  task automatic t_midway_reset();
    repeat (E_REF0 + 1) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R9");
    t_sequence("R9");
  endtask

  initial begin
    #(CLK_NS * 5000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sequence("main");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_midway_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule